// File: doc/BRIEF.md
# Gray code incrementer

The block takes a value in reflected binary Gray code and returns the code that comes next in the Gray sequence. The result is the Gray encoding of the decoded input plus one. It is purely combinational. It has one input bus and one output bus, and it has no clock, no reset and no stored state. A typical use is to advance a Gray-coded pointer or position counter, where the surrounding logic holds the register and this block supplies the next value.

Internally the input is decoded to binary with a running XOR that starts at the most significant bit. The binary value passes through a plus-one stage built from a chain of half adders, which has no second operand and no full adders. The sum is then encoded back to Gray code as b XOR (b >> 1). The width is a parameter with a default of 4. Any carry out of the top bit is dropped, so the last code of the cycle wraps to all zeros.

Top module: `gray_step`

## Requirements
- R1: For every input code g, `q_next` equals the Gray encoding of ((binary value of g) + 1) modulo 2^W. With W = 4, the value 0 is Gray 0000, the value 1 is Gray 0001, and so on.
- R2: For every input, `d_code ^ q_next` has exactly one bit set.
- R3: The last code of the cycle, which is binary 2^W-1 and Gray 1 followed by W-1 zeros (1000 for W = 4), produces all zeros.
- R4: The first code of the cycle, all zeros, produces 0…01. For W = 4 that is 0000 to 0001.
- R5: The output depends only on the present input. When `d_code` changes, `q_next` has the new value with no clock edge in between and without regard to earlier inputs.
- R6: The internal plus-one stage gives binary b + 1 modulo 2^W, and the internal decoder output re-encodes to exactly the input code.
- R7: Starting at any code and applying the block 2^W times visits 2^W distinct codes and returns to the starting code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_code | input | W | Present Gray code value |
| q_next | output | W | Next Gray code value in sequence |

## Verification
Every result is due zero clock cycles after its stimulus, because no register lies between `d_code` and `q_next`. The bench changes the input just after a rising edge of its own sampling clock and compares at the following falling edge. It also makes one comparison after a small delay with no clock edge in between, which shows that the result does not wait for a clock. The chained walk feeds each sampled output back as the next input, so the cycle-length check also involves no clock latency.

// File: rtl/gray_pkg.sv
// Shared constants for the Gray code incrementer.
// Assumes nothing beyond the default width being at least 2.
package gray_pkg;
    localparam int GRAY_W_DEFAULT = 4;
endpackage

// File: rtl/gray_to_bin.sv
// Decodes a reflected binary Gray code to plain binary with a running XOR
// from the most significant bit downward. Purely combinational; W >= 2.
module gray_to_bin #(
    parameter int W = gray_pkg::GRAY_W_DEFAULT
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    // Top bit passes through unchanged.
    assign bin[W-1] = gray[W-1];

    genvar i;
    generate
        for (i = W - 2; i >= 0; i--) begin : g_dec
            // Each lower bit folds in everything above it.
            assign bin[i] = bin[i+1] ^ gray[i];
        end
    endgenerate

    // Decoded value must re-encode to the code it came from.
    always_comb begin
        a_decode_roundtrip_r6: assert ((bin ^ (bin >> 1)) == gray)
            else $error("decode roundtrip broken");
    end
endmodule

// File: rtl/bin_plus_one.sv
// Adds the constant one to a binary value with a half-adder carry chain.
// There is no second operand and no full adder. The carry out of the top
// bit is discarded, so the result wraps modulo 2^W. Combinational; W >= 2.
module bin_plus_one #(
    parameter int W = gray_pkg::GRAY_W_DEFAULT
) (
    input  logic [W-1:0] bin,
    output logic [W-1:0] sum
);
    logic [W-1:0] carry;

    // The constant addend enters as the carry into bit 0.
    assign carry[0] = 1'b1;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_ha
            // Half adder sum bit.
            assign sum[i] = bin[i] ^ carry[i];
            if (i < W - 1) begin : g_cy
                // Carry ripples only while lower bits are all ones.
                assign carry[i+1] = bin[i] & carry[i];
            end
        end
    endgenerate

    // Chain result must equal arithmetic increment modulo 2^W.
    always_comb begin
        a_incr_r6: assert (sum == W'(bin + 1'b1))
            else $error("plus-one stage wrong");
    end
endmodule

// File: rtl/bin_to_gray.sv
// Encodes plain binary to reflected binary Gray code as b ^ (b >> 1).
// Purely combinational.
module bin_to_gray #(
    parameter int W = gray_pkg::GRAY_W_DEFAULT
) (
    input  logic [W-1:0] bin,
    output logic [W-1:0] gray
);
    // Each code bit is the XOR of two adjacent binary bits.
    assign gray = bin ^ (bin >> 1);
endmodule

// File: rtl/gray_step.sv
// Top: returns the Gray code that follows d_code in sequence.
// Chain: decode to binary, add one with a half-adder chain, re-encode.
// No clock, no reset, no state. Assumes W >= 2.
module gray_step #(
    parameter int W = gray_pkg::GRAY_W_DEFAULT
) (
    input  logic [W-1:0] d_code,
    output logic [W-1:0] q_next
);
    localparam logic [W-1:0] LAST_CODE = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] FIRST_CODE = '0;
    localparam logic [W-1:0] SECOND_CODE = W'(1);

    logic [W-1:0] bin_now;
    logic [W-1:0] bin_nxt;

    gray_to_bin #(.W(W)) u_dec (.gray(d_code), .bin(bin_now));
    bin_plus_one #(.W(W)) u_inc (.bin(bin_now), .sum(bin_nxt));
    bin_to_gray #(.W(W)) u_enc (.bin(bin_nxt), .gray(q_next));

    // Port-level checks on the code step.
    always_comb begin
        a_one_bit_r2: assert ($onehot(d_code ^ q_next))
            else $error("step changed other than one bit");
        if (d_code == LAST_CODE) begin
            a_wrap_r3: assert (q_next == FIRST_CODE)
                else $error("last code did not wrap");
        end
        if (d_code == FIRST_CODE) begin
            a_start_r4: assert (q_next == SECOND_CODE)
                else $error("first code step wrong");
        end
    end
endmodule

// File: tb/sim_gray_step.sv
module sim_gray_step;
    localparam int W = 4;
    localparam int N = 1 << W;

    logic clk = 1'b0;
    logic [W-1:0] d_code = '0;
    logic [W-1:0] q_next;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gray_step #(.W(W)) u0 (.d_code(d_code), .q_next(q_next));

    function automatic logic [W-1:0] ref_dec(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    function automatic logic [W-1:0] ref_enc(input logic [W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [W-1:0] ref_next(input logic [W-1:0] g);
        return ref_enc(W'(ref_dec(g) + 1));
    endfunction

    task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: in=%b actual=%b expected=%b", tag, d_code, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [W-1:0] g);
        @(posedge clk);
        d_code = g;
        @(negedge clk);
        cmp(tag, q_next, ref_next(g));
        cmp({tag, " R2 onehot"}, W'($countones(d_code ^ q_next)), W'(1));
    endtask

    initial begin : main
        logic [W-1:0] start;
        logic [W-1:0] cur;
        bit [N-1:0] seen;
        void'($urandom(32'd4242));
        // R4 first code, also the initial state
        @(negedge clk);
        cmp("R4 initial", q_next, 4'b0001);
        apply("R4", 4'b0000);
        cmp("R4 direct", q_next, 4'b0001);
        // R3 wrap
        apply("R3", 4'b1000);
        cmp("R3 direct", q_next, 4'b0000);
        // R1 directed mid-cycle codes
        apply("R1 0001", 4'b0001);
        cmp("R1 0001 direct", q_next, 4'b0011);
        apply("R1 0010", 4'b0010);
        cmp("R1 0010 direct", q_next, 4'b0110);
        apply("R1 0111", 4'b0111);
        cmp("R1 0111 direct", q_next, 4'b0101);
        // R5 change input with no clock edge
        @(posedge clk);
        #2 d_code = 4'b1001;
        #1 cmp("R5 no clock", q_next, 4'b1000);
        // R1 R6 full sweep
        for (int v = 0; v < N; v++) apply("R1 R6 sweep", W'(v));
        // R1 random codes
        for (int k = 0; k < 40; k++) apply("R1 random", W'($urandom));
        // R7 chained walk from a random start
        start = W'($urandom);
        cur = start;
        seen = '0;
        for (int k = 0; k < N; k++) begin
            @(posedge clk);
            d_code = cur;
            @(negedge clk);
            seen[ref_dec(cur)] = 1'b1;
            cur = q_next;
        end
        cmp("R7 return", cur, start);
        n_cmp++;
        if (seen != '1) begin
            n_bad++;
            $display("FAIL R7 distinct: actual=%b expected=%b", seen, {N{1'b1}});
        end
        done = 1'b1;
    end

    initial begin : watchdog
        for (int t = 0; t < 5000 && !done; t++) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule